// File: doc/BRIEF.md
# Periodic Frame List Address Generator

This block keeps a 14-bit micro-frame index that runs freely and turns it into the byte address of the periodic frame list entry the host is currently serving. Each list entry covers eight consecutive micro-frames. The lowest three index bits select the micro-frame slot inside the entry, and the bits above them select the entry. At run time the list can be 1024, 512 or 256 entries long, and the entry number is cut down to fit the chosen length, so the list wraps after its last entry.

The index advances by one on every micro-frame tick while the run input is high, and it holds when run is low. Software can overwrite the index through a synchronous load port. When the slot bits roll over from 7 to 0, the block raises a strobe for one cycle. Downstream fetch logic uses this strobe to start reading the next entry.

Top module: `frame_list_addr_gen`

## Requirements
- R1: While `rst` is high, the index is cleared. After reset, `uslot` is 0, `new_entry` is 0 and `entry_addr` equals `{base_page, 12'h000}`.
- R2: On a clock edge where `run` and `utick` are both high and `ld_en` is low, the index increases by one.
- R3: When `run` is low, a `utick` has no effect: the index, `uslot` and `entry_addr` stay unchanged.
- R4: `uslot` always equals index bits [2:0].
- R5: `entry_addr` is `{base_page, 12'h000}` plus four times the entry number, where the entry number is index bits [12:3] after masking. Bits [1:0] of the address are always 0.
- R6: `size_sel` encoding: 2'b00 means 1024 entries (10 entry bits are kept), 2'b01 means 512 (9 bits), and 2'b10 or 2'b11 means 256 (8 bits). Entry-number bits above the kept width are forced to 0.
- R7: `new_entry` is high for exactly one cycle, namely the cycle right after an edge on which a tick advanced the index from slot 7 to slot 0. It stays low at all other times.
- R8: When `ld_en` is high, the index takes `ld_val` on that edge, even if `run` and `utick` are also high. The new value is visible on the outputs from the next cycle, and a load never raises `new_entry`.
- R9: The 14-bit index wraps from 14'h3FFF to 0 on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables index stepping |
| utick | input | 1 | One-cycle micro-frame tick |
| ld_en | input | 1 | Load the index from `ld_val` |
| ld_val | input | 14 | Index value to load |
| base_page | input | 20 | List base address bits [31:12] (4 KB aligned) |
| size_sel | input | 2 | List length select |
| entry_addr | output | 32 | Byte address of the current list entry |
| uslot | output | 3 | Micro-frame slot within the entry |
| new_entry | output | 1 | One-cycle strobe when a new entry begins |

## Verification
The assertions check on every cycle how the index moves: it steps by one on a running tick, it stays frozen when stopped, a load wins over a tick, and the strobe lasts only one cycle and always coincides with slot 0. The address arithmetic for each size selection depends on values, so it is shown by the bench's table of loaded indices and expected addresses. The bench's directed scenarios show the slot 7 to 0 rollover, the full-width wrap, and the absence of a strobe after a load.

// File: rtl/fl_pkg.sv
package fl_pkg;
    localparam int IDX_W     = 14;
    localparam int SLOT_W    = 3;
    localparam int ENT_W     = IDX_W - SLOT_W - 1;   // 10 entry bits, index[12:3]
    localparam int ADDR_W    = 32;
    localparam int PAGE_BITS = 12;
    localparam int PAGE_W    = ADDR_W - PAGE_BITS;

    typedef enum logic [1:0] {
        LIST_1024 = 2'b00,
        LIST_512  = 2'b01,
        LIST_256  = 2'b10,
        LIST_256B = 2'b11
    } list_size_e;

    typedef struct packed {
        logic [ENT_W-1:0]  entry;
        logic [SLOT_W-1:0] slot;
    } idx_view_t;

    function automatic logic [ENT_W-1:0] entry_mask(input list_size_e sz);
        logic [ENT_W-1:0] m;
        case (sz)
            LIST_1024: m = {ENT_W{1'b1}};
            LIST_512:  m = {1'b0, {(ENT_W-1){1'b1}}};
            default:   m = {2'b00, {(ENT_W-2){1'b1}}};
        endcase
        return m;
    endfunction
endpackage

// File: rtl/uframe_counter.sv
module uframe_counter
    import fl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             utick,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_val,
    output logic [IDX_W-1:0] idx,
    output logic             wrap_strobe
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = {SLOT_W{1'b1}};

    logic step;
    assign step = run && utick && !ld_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx         <= '0;
            wrap_strobe <= 1'b0;
        end else begin
            if (ld_en)
                idx <= ld_val;
            else if (step)
                idx <= idx + 1'b1;
            wrap_strobe <= step && (idx[SLOT_W-1:0] == SLOT_LAST);
        end
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run && utick && !ld_en) |=> idx == $past(idx) + 1'b1);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !ld_en) |=> $stable(idx));

    assert_load_R8: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (idx == $past(ld_val)) && !wrap_strobe);

    assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        wrap_strobe |=> !wrap_strobe);
endmodule

// File: rtl/entry_addr_map.sv
module entry_addr_map
    import fl_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [PAGE_W-1:0] base_page,
    input  list_size_e        size,
    output logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot
);
    localparam int PAD_W = PAGE_BITS - ENT_W;   // byte offset of a 4-byte entry

    idx_view_t        view;
    logic [ENT_W-1:0] ent;

    assign view = idx[IDX_W-2:0];
    assign ent  = view.entry & entry_mask(size);
    assign slot = view.slot;

    generate
        if (PAD_W > 0) begin : g_pad
            assign addr = {base_page, ent, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign addr = {base_page, ent};
        end
    endgenerate
endmodule

// File: rtl/frame_list_addr_gen.sv
module frame_list_addr_gen
    import fl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              utick,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_val,
    input  logic [PAGE_W-1:0] base_page,
    input  logic [1:0]        size_sel,
    output logic [ADDR_W-1:0] entry_addr,
    output logic [SLOT_W-1:0] uslot,
    output logic              new_entry
);
    logic [IDX_W-1:0] idx;
    list_size_e       size;

    assign size = list_size_e'(size_sel);

    uframe_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .utick      (utick),
        .ld_en      (ld_en),
        .ld_val     (ld_val),
        .idx        (idx),
        .wrap_strobe(new_entry)
    );

    entry_addr_map u_map (
        .idx      (idx),
        .base_page(base_page),
        .size     (size),
        .addr     (entry_addr),
        .slot     (uslot)
    );

    assert_strobe_slot0_R7: assert property (@(posedge clk) disable iff (rst)
        new_entry |-> uslot == '0);

    assert_small_list_R6: assert property (@(posedge clk) disable iff (rst)
        (size_sel[1]) |-> entry_addr[PAGE_BITS-1:PAGE_BITS-2] == 2'b00);

    assert_word_align_R5: assert property (@(posedge clk) disable iff (rst)
        entry_addr[1:0] == 2'b00);
endmodule

// File: tb/frame_list_addr_gen_bench.sv
module frame_list_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst, run, utick, ld_en;
    logic [13:0] ld_val;
    logic [19:0] base_page;
    logic [1:0]  size_sel;
    logic [31:0] entry_addr;
    logic [2:0]  uslot;
    logic        new_entry;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    frame_list_addr_gen u_frame_list_addr_gen (
        .clk(clk), .rst(rst), .run(run), .utick(utick), .ld_en(ld_en),
        .ld_val(ld_val), .base_page(base_page), .size_sel(size_sel),
        .entry_addr(entry_addr), .uslot(uslot), .new_entry(new_entry)
    );

    // {size_sel, ld_val, expected address bits [11:0]}
    localparam logic [27:0] VEC [8] = '{
        {2'd0, 14'h0000, 12'h000},
        {2'd0, 14'h1FFF, 12'hFFC},
        {2'd1, 14'h1FFF, 12'h7FC},
        {2'd2, 14'h1FFF, 12'h3FC},
        {2'd0, 14'h0808, 12'h404},
        {2'd1, 14'h0808, 12'h404},
        {2'd2, 14'h0808, 12'h004},
        {2'd3, 14'h2FFF, 12'h3FC}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic r, input logic t, input logic l, input logic [13:0] v);
        @(negedge clk);
        run = r; utick = t; ld_en = l; ld_val = v;
        @(negedge clk);
        run = 0; utick = 0; ld_en = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; run = 0; utick = 0; ld_en = 0; ld_val = '0;
        base_page = 20'hABCDE; size_sel = 2'd0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 slot", {29'd0, uslot}, 32'd0);
        chk("R1 strobe", {31'd0, new_entry}, 32'd0);
        chk("R1 addr", entry_addr, 32'hABCDE000);

        // R5 R6 R4 table walk
        for (int i = 0; i < 8; i++) begin
            size_sel = VEC[i][27:26];
            cyc(0, 0, 1, VEC[i][25:12]);
            chk("R5/R6 addr", entry_addr, {base_page, VEC[i][11:0]});
            chk("R4 slot", {29'd0, uslot}, {29'd0, VEC[i][14:12]});
        end
        size_sel = 2'd0;

        // R2 stepping, R7 rollover strobe
        cyc(0, 0, 1, 14'h0016);                 // entry 2, slot 6
        cyc(1, 1, 0, '0);
        chk("R2 slot 7", {29'd0, uslot}, 32'd7);
        chk("R7 no strobe at 7", {31'd0, new_entry}, 32'd0);
        cyc(1, 1, 0, '0);
        chk("R7 strobe", {31'd0, new_entry}, 32'd1);
        chk("R2 slot 0", {29'd0, uslot}, 32'd0);
        chk("R5 next entry", entry_addr, 32'hABCDE00C);
        @(negedge clk);
        chk("R7 one cycle", {31'd0, new_entry}, 32'd0);

        // R3 stopped tick ignored
        cyc(0, 1, 0, '0);
        chk("R3 slot held", {29'd0, uslot}, 32'd0);
        chk("R3 addr held", entry_addr, 32'hABCDE00C);

        // R8 load wins over tick, no strobe
        cyc(0, 0, 1, 14'h0007);
        cyc(1, 1, 1, 14'h0020);
        chk("R8 load wins", entry_addr, 32'hABCDE010);
        chk("R8 slot", {29'd0, uslot}, 32'd0);
        chk("R8 no strobe", {31'd0, new_entry}, 32'd0);

        // R9 full-width wrap
        cyc(0, 0, 1, 14'h3FFF);
        cyc(1, 1, 0, '0);
        chk("R9 wrap addr", entry_addr, 32'hABCDE000);
        chk("R9 wrap slot", {29'd0, uslot}, 32'd0);
        chk("R9 wrap strobe", {31'd0, new_entry}, 32'd1);

        // R6 list wrap at 256 entries
        size_sel = 2'd2;
        cyc(0, 0, 1, 14'h07FF);                 // entry 255, slot 7
        chk("R6 last of 256", entry_addr, 32'hABCDE3FC);
        cyc(1, 1, 0, '0);
        chk("R6 256 wraps", entry_addr, 32'hABCDE000);

        // R1 reset again mid-run
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk("R1 re-reset", entry_addr, 32'hABCDE000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule